// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is a 32-pin general-purpose I/O port. A register bus sets the level driven on each pin and whether that pin drives at all. The same bus reads back the sampled pad levels. Each pin also watches its own input for an interrupt condition. The condition is one of five kinds: low level, high level, rising edge, falling edge, or any change.

A detected condition sets a sticky status bit. Software clears that bit by writing a one to it. A mask register decides which status bits reach the two interrupt outputs. One output covers the lower sixteen pins and the other covers the upper sixteen. A handler can therefore be bound to each half of the port.

The bus is a simple single-cycle access. `bus_widx` selects a 32-bit register by word index, which is the byte offset divided by four. Writes take effect on the rising edge where `bus_sel` and `bus_we` are both high. Read data is combinational from the current index. Pad inputs are treated as asynchronous and pass through a synchronizer before any use.

Top module: `gpio_irq_port`

## Requirements
- R1: While `rst` is high, and after it falls, every writable register holds 0. Before any bus write this gives `pad_out` = 0, `pad_oe` = 0, and both interrupt outputs low.
- R2: A write to index 0 (byte 0x00) sets the output data word, and `pad_out` follows it after that edge. A write to index 1 (byte 0x04) sets the direction word, and `pad_oe` equals it bit for bit (1 = drive). Reading index 0 returns the written data, not the pad levels.
- R3: Reading index 2 (byte 0x08) returns `pad_in` as sampled through the synchronizer. A change on `pad_in` becomes visible after the second rising edge that follows it. Writes to index 2 change no register.
- R4: Each pin has a 2-bit trigger code: 00 low level, 01 high level, 10 rising edge, 11 falling edge. Pin p < 16 uses bits [2p+1:2p] of index 3 (byte 0x0C). Pin p ≥ 16 uses bits [2(p-16)+1:2(p-16)] of index 4 (byte 0x10). Both words read back as written.
- R5: When bit p of index 7 (byte 0x1C) is 1, pin p flags any change of its input, and its 2-bit code has no effect.
- R6: A level-triggered pin sets its status bit on every cycle its level is active. A clear written while the level is active therefore leaves the bit at 1. When a set and a clear reach a bit in the same cycle, the set wins.
- R7: Status (index 6, byte 0x18) bits stay at 1 until cleared. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: Mask bit p (index 5, byte 0x14) set to 1 enables pin p. `irq_lo` is the OR of status AND mask over pins 0–15. `irq_hi` is the same OR over pins 16–31.
- R9: An input change that meets a pin's trigger sets its status bit on the third rising edge after the change. A masked-in pin's interrupt output rises right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_widx | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the indexed register |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
Register effects on `pad_out`, `pad_oe` and readback are due one edge after the write. The bench samples them on the following falling edge. Pad readback is due on the second rising edge after a pad change, and status and interrupts on the third. The latency tests sample 2 ns after each of those edges, and they expect the old value before the due edge and the new value on it. The vector walk waits five cycles after every pad change and after every clear, so each result there has settled before it is read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PORT_W    = 32;
    localparam int HALF_W    = PORT_W / 2;
    localparam int REG_IDX_W = 3;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_DATA   = 3'd0,
        REG_DIR    = 3'd1,
        REG_PAD    = 3'd2,
        REG_CFG_LO = 3'd3,
        REG_CFG_HI = 3'd4,
        REG_MASK   = 3'd5,
        REG_STAT   = 3'd6,
        REG_BOTH   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] cfg_lo;
        logic [PORT_W-1:0] cfg_hi;
        logic [PORT_W-1:0] mask;
        logic [PORT_W-1:0] both;
    } ctrl_regs_t;

    // Trigger code of one pin from the two configuration words.
    function automatic trig_e pin_code(input logic [PORT_W-1:0] lo,
                                       input logic [PORT_W-1:0] hi,
                                       input int unsigned       pin);
        logic [PORT_W-1:0] word;
        int unsigned       fld;
        word = (pin < HALF_W) ? lo : hi;
        fld  = pin % HALF_W;
        return trig_e'(word[2*fld +: 2]);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end

        p_stage_shift_r3: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> stg[k] == $past(stg[k-1]));
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] cur,
    input  logic [PORT_W-1:0] cfg_lo,
    input  logic [PORT_W-1:0] cfg_hi,
    input  logic [PORT_W-1:0] both,
    output logic [PORT_W-1:0] hit
);
    logic [PORT_W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        trig_e code;
        logic  rise, fall;
        assign code = pin_code(cfg_lo, cfg_hi, p);
        assign rise = cur[p] & ~prev[p];
        assign fall = ~cur[p] & prev[p];

        always_comb begin
            if (both[p]) begin
                hit[p] = rise | fall;
            end else begin
                case (code)
                    TRIG_LOW:  hit[p] = ~cur[p];
                    TRIG_HIGH: hit[p] = cur[p];
                    TRIG_RISE: hit[p] = rise;
                    TRIG_FALL: hit[p] = fall;
                    default:   hit[p] = 1'b0;
                endcase
            end
        end
    end

    // Any-change pins flag exactly the cycles where the input moved.
    p_both_ignores_code_r5: assert property (@(posedge clk) disable iff (rst)
        (both & (hit ^ (cur ^ prev))) == '0);

    // Edge-coded pins never flag while the input is steady.
    p_edge_needs_change_r4: assert property (@(posedge clk) disable iff (rst)
        (hit & ~(cur ^ prev) & (cfg_lo_edge_mask(cfg_lo, cfg_hi))) == '0);

    function automatic logic [PORT_W-1:0] cfg_lo_edge_mask(
        input logic [PORT_W-1:0] lo, input logic [PORT_W-1:0] hi);
        logic [PORT_W-1:0] m;
        for (int i = 0; i < PORT_W; i++) begin
            m[i] = (i < HALF_W) ? lo[2*(i % HALF_W) + 1] : hi[2*(i % HALF_W) + 1];
        end
        return m;
    endfunction
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] hit,
    input  logic [PORT_W-1:0] clr,
    input  logic [PORT_W-1:0] mask,
    output logic [PORT_W-1:0] status,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [PORT_W-1:0] pend;

    // Set has priority over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | hit;
    end

    assign pend   = status & mask;
    assign irq_lo = |pend[HALF_W-1:0];
    assign irq_hi = |pend[PORT_W-1:HALF_W];

    p_hold_until_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(status) & ~$past(clr)) & ~status) == '0);

    p_clear_takes_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (status & $past(clr & ~hit)) == '0);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (status & $past(hit)) == $past(hit));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [REG_IDX_W-1:0] bus_widx,
    input  logic [PORT_W-1:0]    bus_wdata,
    input  logic [PORT_W-1:0]    pad_sync,
    input  logic [PORT_W-1:0]    status,
    output ctrl_regs_t           ctrl,
    output logic [PORT_W-1:0]    stat_clr,
    output logic [PORT_W-1:0]    bus_rdata
);
    reg_idx_e idx;
    logic     wr;

    assign idx = reg_idx_e'(bus_widx);
    assign wr  = bus_sel & bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            case (idx)
                REG_DATA:   ctrl.data   <= bus_wdata;
                REG_DIR:    ctrl.dir    <= bus_wdata;
                REG_CFG_LO: ctrl.cfg_lo <= bus_wdata;
                REG_CFG_HI: ctrl.cfg_hi <= bus_wdata;
                REG_MASK:   ctrl.mask   <= bus_wdata;
                REG_BOTH:   ctrl.both   <= bus_wdata;
                default:    ;
            endcase
        end
    end

    assign stat_clr = (wr && idx == REG_STAT) ? bus_wdata : '0;

    always_comb begin
        case (idx)
            REG_DATA:   bus_rdata = ctrl.data;
            REG_DIR:    bus_rdata = ctrl.dir;
            REG_PAD:    bus_rdata = pad_sync;
            REG_CFG_LO: bus_rdata = ctrl.cfg_lo;
            REG_CFG_HI: bus_rdata = ctrl.cfg_hi;
            REG_MASK:   bus_rdata = ctrl.mask;
            REG_STAT:   bus_rdata = status;
            REG_BOTH:   bus_rdata = ctrl.both;
            default:    bus_rdata = '0;
        endcase
    end

    p_pad_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == REG_PAD) |=> $stable(ctrl));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [REG_IDX_W-1:0] bus_widx,
    input  logic [PORT_W-1:0]    bus_wdata,
    output logic [PORT_W-1:0]    bus_rdata,
    input  logic [PORT_W-1:0]    pad_in,
    output logic [PORT_W-1:0]    pad_out,
    output logic [PORT_W-1:0]    pad_oe,
    output logic                 irq_lo,
    output logic                 irq_hi
);
    ctrl_regs_t        ctrl;
    logic [PORT_W-1:0] pad_sync, hit, stat_clr, status;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pad_in), .dout(pad_sync)
    );

    gpio_trig_detect u_detect (
        .clk(clk), .rst(rst), .cur(pad_sync),
        .cfg_lo(ctrl.cfg_lo), .cfg_hi(ctrl.cfg_hi), .both(ctrl.both),
        .hit(hit)
    );

    gpio_irq_status u_status (
        .clk(clk), .rst(rst), .hit(hit), .clr(stat_clr), .mask(ctrl.mask),
        .status(status), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .pad_sync(pad_sync),
        .status(status), .ctrl(ctrl), .stat_clr(stat_clr),
        .bus_rdata(bus_rdata)
    );

    assign pad_out = ctrl.data;
    assign pad_oe  = ctrl.dir;

    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_widx == REG_DIR) |=> pad_oe == $past(bus_wdata));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mask == '0) |-> (!irq_lo && !irq_hi));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_widx = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int checks = 0, errors = 0;
    logic [31:0] cfg_lo_sh = '0, cfg_hi_sh = '0, both_sh = '0, pad_sh = '0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    gpio_irq_port dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // {pin[4:0], code[1:0], both, v0, v1, expected status}
    localparam logic [10:0] VECS [12] = '{
        {5'd3,  2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
        {5'd3,  2'b00, 1'b0, 1'b1, 1'b0, 1'b1},
        {5'd20, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd20, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1},
        {5'd7,  2'b10, 1'b0, 1'b0, 1'b1, 1'b1},
        {5'd7,  2'b10, 1'b0, 1'b1, 1'b0, 1'b0},
        {5'd25, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1},
        {5'd25, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0},
        {5'd15, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1},
        {5'd16, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1},
        {5'd16, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0},
        {5'd31, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input reg_idx_e idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_widx = idx; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input reg_idx_e idx, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_widx = idx;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_pin(input int pin, input logic v);
        pad_sh[pin] = v;
        pad_in = pad_sh;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pad_out == 0 && pad_oe == 0, "R1 pads", pad_out | pad_oe, 0);
        check(!irq_lo && !irq_hi, "R1 irq", {30'd0, irq_hi, irq_lo}, 0);
        bus_read(REG_MASK, rd); check(rd == 0, "R1 mask", rd, 0);
        bus_read(REG_DIR, rd);  check(rd == 0, "R1 dir", rd, 0);
        bus_read(REG_DATA, rd); check(rd == 0, "R1 data", rd, 0);

        // R2: data and direction
        bus_write(REG_DATA, 32'hA5A5_0F0F);
        bus_write(REG_DIR, 32'hFFFF_0000);
        check(pad_out == 32'hA5A5_0F0F, "R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check(pad_oe == 32'hFFFF_0000, "R2 pad_oe", pad_oe, 32'hFFFF_0000);
        bus_read(REG_DATA, rd);
        check(rd == 32'hA5A5_0F0F, "R2 data readback", rd, 32'hA5A5_0F0F);

        // R3: pad readback latency and write ignored
        @(negedge clk);
        bus_sel = 1'b0; bus_widx = REG_PAD;
        pad_sh = 32'h1234_5678; pad_in = pad_sh;
        @(posedge clk); #2;
        check(bus_rdata == 32'h0, "R3 before second edge", bus_rdata, 0);
        @(posedge clk); #2;
        check(bus_rdata == 32'h1234_5678, "R3 second edge", bus_rdata, 32'h1234_5678);
        bus_write(REG_PAD, 32'hFFFF_FFFF);
        bus_read(REG_PAD, rd);
        check(rd == 32'h1234_5678, "R3 write ignored", rd, 32'h1234_5678);
        pad_sh = '0; pad_in = '0;
        idle(4);

        // R4 R5 R8: vector walk
        for (int i = 0; i < 12; i++) begin
            int   pin;
            logic [1:0] code;
            logic bth, v0, v1, ex;
            {pin[4:0], code, bth, v0, v1, ex} = VECS[i];
            pin = pin & 31;
            if (pin < 16) begin
                cfg_lo_sh[2*pin +: 2] = code;
                bus_write(REG_CFG_LO, cfg_lo_sh);
            end else begin
                cfg_hi_sh[2*(pin-16) +: 2] = code;
                bus_write(REG_CFG_HI, cfg_hi_sh);
            end
            both_sh[pin] = bth;
            bus_write(REG_BOTH, both_sh);
            bus_write(REG_MASK, 32'd1 << pin);
            drive_pin(pin, v0);
            idle(5);
            bus_write(REG_STAT, 32'd1 << pin);
            drive_pin(pin, v1);
            idle(5);
            bus_read(REG_STAT, rd);
            check(rd[pin] == ex, bth ? "R5 both-edge status" : "R4 trigger status",
                  {31'd0, rd[pin]}, {31'd0, ex});
            check(irq_lo == (pin < 16 ? ex : 1'b0) && irq_hi == (pin >= 16 ? ex : 1'b0),
                  "R8 irq half", {30'd0, irq_hi, irq_lo},
                  {30'd0, (pin >= 16) & ex, (pin < 16) & ex});
        end
        bus_read(REG_CFG_LO, rd); check(rd == cfg_lo_sh, "R4 cfg_lo readback", rd, cfg_lo_sh);
        bus_read(REG_CFG_HI, rd); check(rd == cfg_hi_sh, "R4 cfg_hi readback", rd, cfg_hi_sh);

        // R9: latency from pad edge to interrupt, pin 5 rising
        cfg_lo_sh[11:10] = 2'b10;
        bus_write(REG_CFG_LO, cfg_lo_sh);
        bus_write(REG_MASK, 32'd1 << 5);
        drive_pin(5, 1'b0);
        idle(5);
        bus_write(REG_STAT, 32'hFFFF_FFFF);
        @(negedge clk);
        drive_pin(5, 1'b1);
        @(posedge clk); @(posedge clk); #2;
        check(!irq_lo, "R9 not before third edge", {31'd0, irq_lo}, 0);
        @(posedge clk); #2;
        check(irq_lo, "R9 third edge", {31'd0, irq_lo}, 1);

        // R6: level re-sets after clear; pin 9 high level
        cfg_lo_sh[19:18] = 2'b01;
        bus_write(REG_CFG_LO, cfg_lo_sh);
        bus_write(REG_MASK, 32'd1 << 9);
        drive_pin(9, 1'b1);
        idle(5);
        bus_write(REG_STAT, 32'd1 << 9);
        bus_read(REG_STAT, rd);
        check(rd[9] == 1'b1, "R6 level re-set", {31'd0, rd[9]}, 1);
        drive_pin(9, 1'b0);
        idle(5);
        bus_write(REG_STAT, 32'd1 << 9);
        bus_read(REG_STAT, rd);
        check(rd[9] == 1'b0, "R6 cleared when inactive", {31'd0, rd[9]}, 0);

        // R7 R8: pin 9 rising, sticky, masking, write-one-to-clear
        cfg_lo_sh[19:18] = 2'b10;
        bus_write(REG_CFG_LO, cfg_lo_sh);
        drive_pin(9, 1'b1);
        idle(5);
        drive_pin(9, 1'b0);
        idle(5);
        bus_read(REG_STAT, rd);
        check(rd[9] == 1'b1, "R7 sticky", {31'd0, rd[9]}, 1);
        bus_write(REG_MASK, 32'd0);
        check(!irq_lo, "R8 masked off", {31'd0, irq_lo}, 0);
        bus_write(REG_MASK, 32'd1 << 9);
        check(irq_lo && !irq_hi, "R8 masked on", {30'd0, irq_hi, irq_lo}, 1);
        bus_write(REG_STAT, 32'd0);
        bus_read(REG_STAT, rd);
        check(rd[9] == 1'b1, "R7 write zero", {31'd0, rd[9]}, 1);
        bus_write(REG_STAT, ~(32'd1 << 9));
        bus_read(REG_STAT, rd);
        check(rd[9] == 1'b1, "R7 other bits", {31'd0, rd[9]}, 1);
        bus_write(REG_STAT, 32'd1 << 9);
        bus_read(REG_STAT, rd);
        check(rd[9] == 1'b0, "R7 write one", {31'd0, rd[9]}, 0);
        check(!irq_lo, "R8 after clear", {31'd0, irq_lo}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule